// File: doc/BRIEF.md
# Self-Refresh Sequencer

This block moves a DRAM device into self-refresh when the host asks, and brings it back out when the host lets go. It takes the command bus from the normal scheduler for the whole excursion. On entry it forces on-die termination off for a set lead time. It then issues the self-refresh entry command with CKE low, follows it with one NOP, and stops the device clock once the clock-stop delay has elapsed. It keeps CKE low for the minimum residency. On exit it restarts the clock and lets it run for the restart window. It then raises CKE under a NOP, holds the bus on NOP for the exit-to-command delay, and keeps writes blocked for a long lockout after exit.

The host uses a four-phase request/acknowledge pair. Raising `sr_req` asks for entry. `sr_ack` rises once the clock has stopped. Dropping `sr_req` asks for exit, and `sr_ack` falls in the cycle the bus is handed back. The bank tracker supplies `bank_idle`, which is high only when all banks are precharged, the precharge time has passed, no burst is active and earlier timing windows have expired. The refresh scheduler supplies the number of postponed refreshes. Timing values are parameters counted in clock cycles.

Top module: `srx_ctrl`

## Requirements
- R1: An entry request is taken only in a cycle where `bank_idle` is 1 and `postponed` is at most MAX_POSTPONE (8). Otherwise the request has no effect: `cmd_own` stays 0 and `cke` stays 1. A taken request raises `cmd_own` in the next cycle.
- R2: While `cmd_own` is 0, `odt` equals `odt_in`. From the first owned cycle, `odt` is 0. The entry command comes exactly ODTL+1 cycles after that first owned cycle.
- R3: The entry command is `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1, with `cke`=0 in the same cycle.
- R4: The cycle after the entry command carries a NOP (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1) with `cke` still 0.
- R5: `cke` stays 0 from the entry command until exit. `ck_en` rises in the cycle after the later of two events: the first cycle in which `sr_req` is seen low, and the cycle TCKESR cycles after the entry command.
- R6: `ck_en` falls exactly TCKSRE cycles after the entry command (TCKSRE at least 3). It is high for exactly TCKSRX cycles before `cke` rises.
- R7: `cke` rises together with a NOP on the command bus.
- R8: `wr_block` is 1 from the entry command through the cycle WR_LOCK-1 cycles after the exit cycle. It is 0 from WR_LOCK cycles after the exit cycle onward.
- R9: `sr_ack` rises in the cycle `ck_en` falls. After exit the bus is held on NOP for TXS cycles (TXS at least 2). `cmd_own` and `sr_ack` both fall TXS cycles after the exit cycle.
- R10: After synchronous reset, `cke`=1, `ck_en`=1, `cmd_own`=0, `sr_ack`=0 and `wr_block`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sr_req | input | 1 | Host level request: 1 = be in self-refresh |
| sr_ack | output | 1 | High from clock stop until the bus is returned |
| bank_idle | input | 1 | All banks precharged, precharge time met, no burst, prior windows expired |
| postponed | input | PW | Number of refreshes currently postponed |
| odt_in | input | 1 | Termination control from the normal scheduler |
| cke | output | 1 | Clock enable to the device |
| odt | output | 1 | Termination control to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cmd_own | output | 1 | High while this block drives the command bus |
| ck_en | output | 1 | Device clock gate: 0 = clock stopped |
| wr_block | output | 1 | Writes and write leveling forbidden |

## Verification
The bench builds the block with ODTL=2, TCKSRE=4, TCKESR=6, TCKSRX=4, TXS=5 and WR_LOCK=20. These values keep every window short enough to sweep in full. Because the clock stops before the residency has expired, an early exit request must be held off by the residency counter, while a late one sets the exit time itself. Sweeping all sixteen postponed counts with both settings of `bank_idle` covers the acceptance boundary at eight. The host hold time after acknowledge is varied from zero to eight, so both branches of the exit rule are exercised, and the 20-cycle write lockout can be measured to its exact end.

// File: rtl/srx_pkg.sv
// Shared types for the self-refresh sequencer.
// Assumes a four-wire command bus ordered {cs_n, ras_n, cas_n, we_n}.
package srx_pkg;

    typedef logic [3:0] srx_cmd_t;

    localparam srx_cmd_t CMD_NOP  = 4'b0111;
    localparam srx_cmd_t CMD_DESL = 4'b1111;
    localparam srx_cmd_t CMD_SRE  = 4'b0001;

    typedef enum logic [3:0] {
        S_IDLE      = 4'd0,
        S_ODT_OFF   = 4'd1,
        S_ENTER     = 4'd2,
        S_POST_NOP  = 4'd3,
        S_STOP_WAIT = 4'd4,
        S_RESIDE    = 4'd5,
        S_RESTART   = 4'd6,
        S_EXIT      = 4'd7,
        S_XS_WAIT   = 4'd8
    } srx_state_e;

    function automatic int srx_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/srx_phase_timer.sv
// Saturating up-counter that times each phase of the sequence.
// Assumes: clr restarts the count at zero in the following cycle;
// the count stops at LIMIT.
module srx_phase_timer #(
    parameter int CW    = 4,
    parameter int LIMIT = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CAP = CW'(LIMIT);

    // Count cycles since the last clear, holding at the cap.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != CAP) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/srx_wr_lockout.sv
// Write lockout around self-refresh.
// Blocks writes while the device is in self-refresh (hold), and for
// WR_LOCK cycles starting with the exit cycle (start).
// Assumes start is a single-cycle pulse and WR_LOCK >= 1.
module srx_wr_lockout #(
    parameter int WR_LOCK = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic start,
    output logic wr_block
);
    localparam int LW = $clog2(WR_LOCK + 1);
    localparam logic [LW-1:0] RELOAD = LW'(WR_LOCK - 1);

    logic [LW-1:0] remain;

    // Load the remaining lockout at exit, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (start)          remain <= RELOAD;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign wr_block = hold || start || (remain != '0);
endmodule

// File: rtl/srx_fsm.sv
// Phase sequencer for self-refresh entry and exit.
// Walks: ODT off -> entry command -> NOP -> wait for clock stop ->
// residency -> clock restart -> exit -> exit-to-command wait.
// Assumes the phase timer is cleared on every entry into ODT_OFF,
// ENTER, RESTART and EXIT; it runs on through the entry chain and into
// XS_WAIT, so those windows are measured from ENTER and from EXIT.
// Assumes TCKSRE >= 3 and TXS >= 2 for exact window lengths.
module srx_fsm
    import srx_pkg::*;
#(
    parameter int CW       = 8,
    parameter int ODT_LEAD = 7,
    parameter int TCKSRE   = 5,
    parameter int TCKESR   = 4,
    parameter int TCKSRX   = 5,
    parameter int TXS      = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sr_req,
    input  logic          entry_ok,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cke,
    output logic          ck_en,
    output srx_cmd_t      cmd,
    output logic          own,
    output logic          ack,
    output logic          sr_hold,
    output logic          exit_pulse
);
    localparam logic [CW-1:0] LEAD_LAST = CW'(ODT_LEAD - 1);
    localparam logic [CW-1:0] STOP_LAST = CW'(TCKSRE - 1);
    localparam logic [CW-1:0] RES_MIN   = CW'(TCKESR);
    localparam logic [CW-1:0] RUN_LAST  = CW'(TCKSRX - 1);
    localparam logic [CW-1:0] XS_LAST   = CW'(TXS - 1);

    srx_state_e state, state_n;

    // Register the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Choose the next phase from the request, idle check and phase timer.
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:      if (sr_req && entry_ok) state_n = S_ODT_OFF;
            S_ODT_OFF:   if (cnt >= LEAD_LAST)   state_n = S_ENTER;
            S_ENTER:                             state_n = S_POST_NOP;
            S_POST_NOP:                          state_n = S_STOP_WAIT;
            S_STOP_WAIT: if (cnt >= STOP_LAST)   state_n = S_RESIDE;
            S_RESIDE:    if (!sr_req && cnt >= RES_MIN) state_n = S_RESTART;
            S_RESTART:   if (cnt >= RUN_LAST)    state_n = S_EXIT;
            S_EXIT:                              state_n = S_XS_WAIT;
            S_XS_WAIT:   if (cnt >= XS_LAST)     state_n = S_IDLE;
            default:                             state_n = S_IDLE;
        endcase
    end

    // Restart the phase timer on phase changes that open a new window.
    always_comb begin
        cnt_clr = (state_n != state) &&
                  !(state_n inside {S_POST_NOP, S_STOP_WAIT, S_RESIDE, S_XS_WAIT});
    end

    // Drive device pins and handshake from the current phase.
    always_comb begin
        own        = (state != S_IDLE);
        cke        = !(state inside {S_ENTER, S_POST_NOP, S_STOP_WAIT, S_RESIDE, S_RESTART});
        ck_en      = (state != S_RESIDE);
        ack        = (state inside {S_RESIDE, S_RESTART, S_EXIT, S_XS_WAIT});
        sr_hold    = !cke;
        exit_pulse = (state == S_EXIT);
        unique case (state)
            S_ENTER:                          cmd = CMD_SRE;
            S_STOP_WAIT, S_RESIDE, S_RESTART: cmd = CMD_DESL;
            default:                          cmd = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/srx_ctrl.sv
// Self-refresh sequencer top level.
// Gates entry on bank idleness and the postponed-refresh limit. Owns
// the command bus, CKE, ODT and the clock gate for the whole
// excursion, and raises a write lockout after exit.
// Assumes postponed and bank_idle are synchronous to clk.
module srx_ctrl
    import srx_pkg::*;
#(
    parameter int ODTL         = 6,
    parameter int TCKSRE       = 5,
    parameter int TCKESR       = 4,
    parameter int TCKSRX       = 5,
    parameter int TXS          = 200,
    parameter int WR_LOCK      = 512,
    parameter int MAX_POSTPONE = 8,
    parameter int PW           = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sr_req,
    output logic          sr_ack,
    input  logic          bank_idle,
    input  logic [PW-1:0] postponed,
    input  logic          odt_in,
    output logic          cke,
    output logic          odt,
    output logic          cs_n,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          cmd_own,
    output logic          ck_en,
    output logic          wr_block
);
    localparam int ODT_LEAD = ODTL + 1;
    localparam int CMAX = srx_max(srx_max(srx_max(ODT_LEAD, TCKSRE),
                                          srx_max(TCKESR, TCKSRX)), TXS);
    localparam int CW = $clog2(CMAX + 1);

    logic          entry_ok;
    logic          cnt_clr;
    logic [CW-1:0] cnt;
    logic          sr_hold;
    logic          exit_pulse;
    srx_cmd_t      cmd;

    assign entry_ok = bank_idle && (postponed <= PW'(MAX_POSTPONE));

    srx_phase_timer #(.CW(CW), .LIMIT(CMAX)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    srx_fsm #(
        .CW       (CW),
        .ODT_LEAD (ODT_LEAD),
        .TCKSRE   (TCKSRE),
        .TCKESR   (TCKESR),
        .TCKSRX   (TCKSRX),
        .TXS      (TXS)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_req     (sr_req),
        .entry_ok   (entry_ok),
        .cnt        (cnt),
        .cnt_clr    (cnt_clr),
        .cke        (cke),
        .ck_en      (ck_en),
        .cmd        (cmd),
        .own        (cmd_own),
        .ack        (sr_ack),
        .sr_hold    (sr_hold),
        .exit_pulse (exit_pulse)
    );

    srx_wr_lockout #(.WR_LOCK(WR_LOCK)) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (sr_hold),
        .start    (exit_pulse),
        .wr_block (wr_block)
    );

    assign odt = cmd_own ? 1'b0 : odt_in;
    assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/srx_ctrl_chk.sv
// Port-level checker for srx_ctrl, attached with bind.
// Measures windows with its own saturating counters.
module srx_ctrl_chk #(
    parameter int ODTL    = 6,
    parameter int TCKESR  = 4,
    parameter int TCKSRX  = 5,
    parameter int WR_LOCK = 512
) (
    input logic clk,
    input logic rst_n,
    input logic sr_ack,
    input logic cke,
    input logic odt,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic cmd_own,
    input logic ck_en,
    input logic wr_block
);
    int unsigned odt_low_n, cke_low_n, ck_run_n, since_exit;
    logic cke_q;
    logic is_sre, is_quiet;

    assign is_sre   = cmd_own && !cs_n && !ras_n && !cas_n && we_n;
    assign is_quiet = cs_n || (ras_n && cas_n && we_n);

    // Track run lengths of ODT low, CKE low, running clock and time since exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odt_low_n  <= 0;
            cke_low_n  <= 0;
            ck_run_n   <= 0;
            since_exit <= WR_LOCK;
            cke_q      <= 1'b1;
        end else begin
            odt_low_n <= odt    ? 0 : odt_low_n + 1;
            cke_low_n <= cke    ? 0 : cke_low_n + 1;
            ck_run_n  <= !ck_en ? 0 : ((ck_run_n < 32'hFFFF) ? ck_run_n + 1 : ck_run_n);
            cke_q     <= cke;
            if (cke && !cke_q)                 since_exit <= 1;
            else if (since_exit < WR_LOCK)     since_exit <= since_exit + 1;
        end
    end

    p_odt_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_sre |-> (!odt && odt_low_n >= ODTL + 1));

    p_sre_cke_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_sre |-> !cke);

    p_nop_after_sre_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_sre |=> (cmd_own && !cs_n && ras_n && cas_n && we_n && !cke));

    p_residency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cke_q) |-> (cke_low_n >= TCKESR));

    p_clk_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cke_q) |-> (ck_en && ck_run_n >= TCKSRX));

    p_clk_off_cke_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_en |-> !cke);

    p_exit_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cke_q) |-> is_quiet);

    p_wr_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cke && !cke_q) || since_exit < WR_LOCK) |-> wr_block);

    p_ack_owned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ack |-> cmd_own);
endmodule

bind srx_ctrl srx_ctrl_chk #(
    .ODTL    (ODTL),
    .TCKESR  (TCKESR),
    .TCKSRX  (TCKSRX),
    .WR_LOCK (WR_LOCK)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sr_ack   (sr_ack),
    .cke      (cke),
    .odt      (odt),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cmd_own  (cmd_own),
    .ck_en    (ck_en),
    .wr_block (wr_block)
);

// File: tb/srx_ctrl_tb_top.sv
// Sweeps bank_idle x postponed count; for each accepted entry, traces
// the full excursion and checks every window against arithmetic.
module srx_ctrl_tb_top;
    localparam int ODTL    = 2;
    localparam int TCKSRE  = 4;
    localparam int TCKESR  = 6;
    localparam int TCKSRX  = 4;
    localparam int TXS     = 5;
    localparam int WR_LOCK = 20;
    localparam int MAXP    = 8;
    localparam int PW      = 4;

    logic clk = 1'b0;
    logic rst_n, sr_req, bank_idle, odt_in;
    logic [PW-1:0] postponed;
    logic sr_ack, cke, odt, cs_n, ras_n, cas_n, we_n, cmd_own, ck_en, wr_block;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    srx_ctrl #(
        .ODTL(ODTL), .TCKSRE(TCKSRE), .TCKESR(TCKESR), .TCKSRX(TCKSRX),
        .TXS(TXS), .WR_LOCK(WR_LOCK), .MAX_POSTPONE(MAXP), .PW(PW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .sr_ack(sr_ack),
        .bank_idle(bank_idle), .postponed(postponed), .odt_in(odt_in),
        .cke(cke), .odt(odt), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cmd_own(cmd_own), .ck_en(ck_en), .wr_block(wr_block)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Trace one accepted excursion; r=0 is the first owned cycle.
    task automatic run_seq(input int hold);
        int t_sre = -1, t_stop = -1, t_ack = -1, t_run = -1;
        int t_exit = -1, t_free = -1, t_wr = -1;
        int odt_bad = 0, xs_bad = 0, low_bad = 0;
        int cke_at_sre = 1, nop_after = 0, exit_nop = 0, exit_ck = 0;
        int ack_at_free = 1, wr_at_stop = 0;
        logic [3:0] c;
        bank_idle = 1'b0;   // idle status must not matter once committed
        for (int r = 0; r < 200; r++) begin
            if (r > 0) step();
            c = {cs_n, ras_n, cas_n, we_n};
            if (t_sre < 0 && odt != 1'b0) odt_bad++;
            if (t_sre < 0 && c == 4'b0001) begin t_sre = r; cke_at_sre = cke; end
            else if (t_sre >= 0 && r == t_sre + 1)
                nop_after = (c == 4'b0111 && !cke) ? 1 : 0;
            if (t_stop < 0 && !ck_en) begin t_stop = r; wr_at_stop = wr_block; end
            if (t_ack < 0 && sr_ack) t_ack = r;
            if (t_ack >= 0 && r == t_ack + hold) sr_req = 1'b0;
            if (t_stop >= 0 && t_run < 0 && ck_en) t_run = r;
            if (t_sre >= 0 && t_exit < 0 && r > t_sre) begin
                if (cke) begin
                    t_exit = r; exit_nop = (c == 4'b0111) ? 1 : 0; exit_ck = ck_en;
                end
            end
            if (t_sre >= 0 && t_exit < 0 && cke) low_bad++;
            if (t_exit >= 0 && t_free < 0) begin
                if (!cmd_own) begin t_free = r; ack_at_free = sr_ack; end
                else if (c != 4'b0111) xs_bad++;
            end
            if (t_exit >= 0 && t_wr < 0 && !wr_block) t_wr = r;
            if (t_wr >= 0 && t_free >= 0) break;
        end
        chk("R2 entry lead", t_sre, ODTL + 1);
        chk("R2 odt forced low", odt_bad, 0);
        chk("R3 cke low with entry", cke_at_sre, 0);
        chk("R4 nop after entry", nop_after, 1);
        chk("R6 clock stop delay", t_stop - t_sre, TCKSRE);
        chk("R9 ack at clock stop", t_ack, t_stop);
        chk("R8 block during residency", wr_at_stop, 1);
        chk("R5 clock restart time", t_run, imax(t_ack + hold, t_sre + TCKESR) + 1);
        chk("R5 cke held low", low_bad, 0);
        chk("R6 restart window", t_exit - t_run, TCKSRX);
        chk("R7 exit with nop", exit_nop, 1);
        chk("R6 clock running at exit", exit_ck, 1);
        chk("R9 bus release", t_free - t_exit, TXS);
        chk("R9 ack drop", ack_at_free, 0);
        chk("R9 nop-only window", xs_bad, 0);
        chk("R8 lockout end", t_wr - t_exit, WR_LOCK);
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sr_req = 1'b0; bank_idle = 1'b0; postponed = '0; odt_in = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R10 cke", cke, 1);
        chk("R10 ck_en", ck_en, 1);
        chk("R10 cmd_own", cmd_own, 0);
        chk("R10 sr_ack", sr_ack, 0);
        chk("R10 wr_block", wr_block, 0);
        chk("R2 odt pass high", odt, 1);
        odt_in = 1'b0;
        step();
        chk("R2 odt pass low", odt, 0);
        odt_in = 1'b1;

        for (int idl = 0; idl < 2; idl++) begin
            for (int p = 0; p < 16; p++) begin
                bit accept;
                accept    = (idl == 1) && (p <= MAXP);
                bank_idle = idl[0];
                postponed = PW'(p);
                sr_req    = 1'b1;
                step();
                chk($sformatf("R1 accept idle=%0d post=%0d", idl, p), cmd_own, accept);
                if (!accept) begin
                    repeat (3) step();
                    chk("R1 refused keeps bus", cmd_own, 0);
                    chk("R1 refused keeps cke", cke, 1);
                    sr_req = 1'b0;
                    step();
                end else begin
                    run_seq(p);
                    step();
                    chk("R1 back to normal", cmd_own, 0);
                end
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule